// File: doc/BRIEF.md
# Paired-Register Logical Right Shifter

This execution unit joins a 32-bit high register and a 32-bit low register into a single 64-bit operand. It shifts that operand logically to the right by a count taken from the lowest six bits of a 16-bit count register. It writes the result back to the two registers and updates the negative, zero and carry flags. The unit acts only when the instruction strobe is high and the opcode matches its own code. Each operation takes a single clock edge.

A repeat prefix cannot apply to this operation. When the operation arrives while a repeat is armed, the unit shifts once and pulses a clear for the repeat counter.

Top module: `shr64_unit`

## Requirements
- R1: The unit updates its registers and flags only on a clock edge where `valid_i` is high and `opcode_i` equals 16'h565B. On every other edge, all outputs except `rpt_clr_o` keep their values.
- R2: The operand is {`hi_i`,`lo_i`}, with `hi_i` as bits 63..32. It is shifted right by `shcnt_i[5:0]` (0 to 63), and bits 15..6 of `shcnt_i` have no effect on any result.
- R3: Vacated upper bit positions are filled with zeros.
- R4: `c_o` is 0 when the count is 0. Otherwise it equals original operand bit (count-1).
- R5: `n_o` equals bit 63 of the result, which is `hi_o[31]`.
- R6: `z_o` is 1 exactly when all 64 result bits are zero.
- R7: A count of 0 leaves `hi_o`/`lo_o` equal to the input operand, and N and Z are still recomputed from it.
- R8: `rpt_clr_o` is high for exactly the cycle after an executed operation that saw `rpt_active_i` high, and low otherwise.
- R9: An asynchronous active-low reset `rst_ni` clears both registers, all flags and `rpt_clr_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Instruction valid strobe |
| opcode_i | input | 16 | Instruction opcode |
| hi_i | input | 32 | Current high register value |
| lo_i | input | 32 | Current low register value |
| shcnt_i | input | 16 | Shift count register; only bits 5..0 are used |
| rpt_active_i | input | 1 | A repeat is armed |
| hi_o | output | 32 | Updated high register |
| lo_o | output | 32 | Updated low register |
| n_o | output | 1 | Negative flag |
| z_o | output | 1 | Zero flag |
| c_o | output | 1 | Carry flag |
| rpt_clr_o | output | 1 | Repeat counter clear |

## Verification
Every result is registered once. The registers, the three flags and the repeat clear all become valid on the first rising edge after the operands are presented, with no further latency. The bench drives inputs on the falling edge. On the next falling edge it compares each output with a behavioural model that it updated from the same inputs, so every comparison falls exactly one edge after its stimulus. The stimulus covers the counts 0, 1, 31, 32 and 63 with junk in the upper count bits, along with random operands, strobe-low and wrong-opcode cycles, armed and unarmed repeats, and a reset in the middle of a run.

// File: rtl/shr64_pkg.sv
package shr64_pkg;
  localparam logic [15:0] OPC_SHR64 = 16'h565B;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
  } flags_t;
endpackage

// File: rtl/shr64_barrel.sv
// Logarithmic right shifter, zero fill
module shr64_barrel #(
  parameter int W  = 65,
  parameter int SW = 6
) (
  input  logic [W-1:0]  d_i,
  input  logic [SW-1:0] amt_i,
  output logic [W-1:0]  q_o
);
  logic [W-1:0] stg [SW+1];

  assign stg[0] = d_i;

  for (genvar i = 0; i < SW; i++) begin : g_stage
    localparam int STEP = 1 << i;
    assign stg[i+1] = amt_i[i] ? (stg[i] >> STEP) : stg[i];
  end

  assign q_o = stg[SW];
endmodule

// File: rtl/shr64_flags.sv
module shr64_flags #(
  parameter int W = 64
) (
  input  logic [W-1:0]     res_i,
  input  logic             cout_i,
  output shr64_pkg::flags_t flg_o
);
  always_comb begin
    flg_o.n = res_i[W-1];
    flg_o.z = ~|res_i;
    flg_o.c = cout_i;
  end
endmodule

// File: rtl/shr64_unit.sv
module shr64_unit #(
  parameter int DATA_W  = 32,
  parameter int CNT_W   = 16,
  parameter int SH_BITS = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [15:0]       opcode_i,
  input  logic [DATA_W-1:0] hi_i,
  input  logic [DATA_W-1:0] lo_i,
  input  logic [CNT_W-1:0]  shcnt_i,
  input  logic              rpt_active_i,
  output logic [DATA_W-1:0] hi_o,
  output logic [DATA_W-1:0] lo_o,
  output logic              n_o,
  output logic              z_o,
  output logic              c_o,
  output logic              rpt_clr_o
);
  import shr64_pkg::*;

  localparam int OP_W  = 2 * DATA_W;
  localparam int EXT_W = OP_W + 1;

  logic               fire;
  logic [SH_BITS-1:0] amt;
  logic [EXT_W-1:0]   ext_in, ext_out;
  logic [OP_W-1:0]    res;
  flags_t             flg_nxt;

  assign fire = valid_i && (opcode_i == OPC_SHR64);
  assign amt  = shcnt_i[SH_BITS-1:0];

  // guard bit below LSB catches the last bit out; stays 0 for a zero shift
  assign ext_in = {hi_i, lo_i, 1'b0};

  shr64_barrel #(.W(EXT_W), .SW(SH_BITS)) u_barrel (
    .d_i   (ext_in),
    .amt_i (amt),
    .q_o   (ext_out)
  );

  assign res = ext_out[EXT_W-1:1];

  shr64_flags #(.W(OP_W)) u_flags (
    .res_i  (res),
    .cout_i (ext_out[0]),
    .flg_o  (flg_nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_o      <= '0;
      lo_o      <= '0;
      n_o       <= 1'b0;
      z_o       <= 1'b0;
      c_o       <= 1'b0;
      rpt_clr_o <= 1'b0;
    end else begin
      rpt_clr_o <= fire && rpt_active_i;
      if (fire) begin
        hi_o <= res[OP_W-1:DATA_W];
        lo_o <= res[DATA_W-1:0];
        n_o  <= flg_nxt.n;
        z_o  <= flg_nxt.z;
        c_o  <= flg_nxt.c;
      end
    end
  end

  p_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fire |=> ($stable(hi_o) && $stable(lo_o) && $stable(n_o) && $stable(z_o) && $stable(c_o)));

  p_zfill_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && amt != '0) |=> !hi_o[DATA_W-1]);

  p_carry_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && amt == '0) |=> !c_o);

  p_neg_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire |=> (n_o == hi_o[DATA_W-1]));

  p_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire |=> (z_o == ({hi_o, lo_o} == '0)));

  p_noshift_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && amt == '0) |=> ({hi_o, lo_o} == $past({hi_i, lo_i})));

  p_rptclr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rpt_clr_o |-> $past(fire && rpt_active_i));
endmodule

// File: tb/shr64_unit_tb.sv
`timescale 1ns/1ps
module shr64_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [15:0] opc = '0;
  logic [31:0] hi = '0, lo = '0;
  logic [15:0] cnt = '0;
  logic        rpt = 1'b0;
  logic [31:0] hi_q, lo_q;
  logic        n_q, z_q, c_q, clr_q;

  int n_chk = 0, n_fail = 0, cyc = 0;

  logic [63:0] e_res = '0;
  logic        e_n = 0, e_z = 0, e_c = 0, e_clr = 0;

  always #2.5 clk = ~clk;

  shr64_unit u_dut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .opcode_i(opc),
    .hi_i(hi), .lo_i(lo), .shcnt_i(cnt), .rpt_active_i(rpt),
    .hi_o(hi_q), .lo_o(lo_q), .n_o(n_q), .z_o(z_q), .c_o(c_q), .rpt_clr_o(clr_q)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run hung, got %0d cycles exp < 100000", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic chk(string req);
    n_chk++;
    if ({hi_q, lo_q} !== e_res || n_q !== e_n || z_q !== e_z || c_q !== e_c || clr_q !== e_clr) begin
      n_fail++;
      $display("FAIL %s: got res=%h n=%b z=%b c=%b clr=%b exp res=%h n=%b z=%b c=%b clr=%b",
               req, {hi_q, lo_q}, n_q, z_q, c_q, clr_q, e_res, e_n, e_z, e_c, e_clr);
    end
  endtask

  // present one cycle of stimulus, update the model, check one edge later
  task automatic step(input logic v, input logic [15:0] op, input logic [63:0] val,
                      input logic [15:0] sc, input logic r, input string req);
    int a;
    valid = v; opc = op; {hi, lo} = val; cnt = sc; rpt = r;
    a = int'(sc[5:0]);
    e_clr = 1'b0;
    if (v && op == 16'h565B) begin
      e_res = val >> a;
      e_c   = (a == 0) ? 1'b0 : val[a-1];
      e_n   = e_res[63];
      e_z   = (e_res == 64'd0);
      e_clr = r;
    end
    @(negedge clk);
    chk(req);
  endtask

  initial begin
    logic [63:0] v64;
    repeat (3) @(negedge clk);
    chk("R9 reset");
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 idle after reset");

    // corner counts, junk in upper count bits (R2)
    step(1, 16'h565B, 64'hF123_4567_89AB_CDEF, 16'hFFC0, 0, "R7 R4 zero shift");
    step(1, 16'h565B, 64'h8000_0000_0000_0001, 16'h0001, 0, "R4 R3 shift 1");
    step(1, 16'h565B, 64'hFFFF_FFFF_8000_0000, 16'hAB9F, 0, "R2 shift 31");
    step(1, 16'h565B, 64'h8765_4321_FFFF_FFFF, 16'h1220, 0, "R2 R3 shift 32");
    step(1, 16'h565B, 64'h8000_0000_0000_0000, 16'hFFFF, 0, "R3 R5 shift 63");
    step(1, 16'h565B, 64'h7FFF_FFFF_FFFF_FFFF, 16'h003F, 0, "R6 R4 zero result");
    step(1, 16'h565B, 64'h0, 16'h0000, 0, "R6 R7 zero operand");
    step(1, 16'h565B, 64'h8000_0000_0000_0000, 16'h0000, 0, "R5 R7 negative no shift");

    // non-firing cycles must hold (R1)
    step(0, 16'h565B, 64'h1234_5678_9ABC_DEF0, 16'h0004, 1, "R1 R8 valid low");
    step(1, 16'h565A, 64'h1234_5678_9ABC_DEF0, 16'h0004, 1, "R1 R8 wrong opcode");

    // repeat armed (R8)
    step(1, 16'h565B, 64'hDEAD_BEEF_CAFE_F00D, 16'h0008, 1, "R8 repeat armed");
    step(0, 16'h0000, 64'h0, 16'h0, 0, "R8 clear one cycle only");

    for (int i = 0; i < 200; i++) begin
      v64 = {$urandom, $urandom};
      step(($urandom % 4) != 0, (($urandom % 8) == 0) ? 16'h1111 : 16'h565B,
           v64, 16'($urandom), 1'($urandom), "R2 random");
    end

    // async reset in mid-run (R9)
    step(1, 16'h565B, 64'hFFFF_FFFF_FFFF_FFFF, 16'h0002, 1, "R2 pre-reset");
    #1 rst_n = 1'b0;
    e_res = '0; e_n = 0; e_z = 0; e_c = 0; e_clr = 0;
    #0.5;
    chk("R9 async reset");
    @(negedge clk);
    rst_n = 1'b1;
    step(1, 16'h565B, 64'h0000_0001_0000_0000, 16'h0020, 0, "R4 after reset");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule